// File: doc/BRIEF.md
# Accumulator and Status Register Access Unit

This block sits beside a multiply-accumulate datapath and carries out every register transfer that does not involve the multiplier. It holds four 48-bit accumulators, a status register with mode bits, flags and per-accumulator overflow bits, and an address mask register. A decoded operation code, with a 32-bit source value and a few fields taken from the instruction word, selects one transfer per cycle. Reads return a registered 32-bit result one cycle later.

Values are converted on the way in and out according to the mode bits: fractional, signed integer or unsigned integer. When saturation is enabled, integer reads clamp to the 32-bit range; when it is off, integer reads return the raw low word. Accumulator writes and copies clear and then recompute the condition flags from the written accumulator. A separate transfer presents the low status flags to the processor as condition codes with the extend bit cleared.

Accumulator layout: integer view uses bits 31:0 as the main word and bits 47:32 as a 16-bit extension. Fractional view uses bits 39:8 as the main word, bits 47:40 as an upper extension byte and bits 7:0 as a lower extension byte.

Top module: `acc_xfer_unit`

## Requirements
- R1: After reset res=0, res_vld=0, ccr_we=0, all accumulators are zero, status reads as 0 and the mask reads as 0xFFFFFFFF.
- R2: Operation codes: 0 idle, 1 read accumulator, 2 write accumulator, 3 copy accumulator, 4 read status, 5 write status, 6 read mask, 7 write mask, 8 read extension, 9 write extension, 10 status to condition codes, 11-15 idle. res and res_vld update one cycle after the op; res_vld is 1 exactly after ops 1, 4, 6 and 8.
- R3: Status bits: 3 N, 2 Z, 1 V, 0 EV, 4 saturate enable, 5 signed, 6 fractional, 11:8 sticky overflow of accumulators 3..0. An accumulator read returns bits 39:8 when fractional is set (clamped to 0x7FFFFFFF/0x80000000 by bit 47 if saturate is set and bits 47:39 are not all equal); otherwise bits 31:0 when saturate is clear; otherwise, signed, bits 31:0 or 0x7FFFFFFF/0x80000000 if bits 47:31 are not all equal; otherwise, unsigned, bits 31:0 or 0xFFFFFFFF if bits 47:32 are nonzero.
- R4: A read of an accumulator with rd_clr=1 returns the old value and leaves the accumulator zero.
- R5: A write stores {8 sign bits, src, 8 zeros} in fractional mode, src sign-extended in signed mode, src zero-extended otherwise, into accumulator dst_sel, and sets flags: N=bit 47, Z=all zero, V=sticky overflow bit of that accumulator, EV=bits 47:39 not all equal (fractional), bits 47:31 not all equal (signed), bits 47:32 nonzero (unsigned). Status bits 11:4 are unchanged.
- R6: A copy moves accumulator src_sel into accumulator dst_sel and sets the flags from the new value as in R5.
- R7: A status write stores src masked with 0x00000F7F; every other bit reads back as zero.
- R8: A mask write stores src OR 0xFFFF0000.
- R9: Extension access uses accumulators 2/3 when dst_sel[1]=1, else 0/1 (even one = A, odd one = B). Fractional packing: {B[47:40], B[7:0], A[47:40], A[7:0]}; integer packing: {B[47:32], A[47:32]}. Writes use the same packing and do not touch the flags.
- R10: Status to condition codes sets ccr={0, status[3:0]} with ccr_we=1 for one cycle, one cycle after the op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| dst_sel | input | 2 | Target accumulator (instruction bits 10:9); bit 1 picks the extension pair |
| src_sel | input | 2 | Source accumulator for a copy |
| rd_clr | input | 1 | Clear the accumulator after a read |
| src | input | 32 | Source value |
| res | output | 32 | Registered result |
| res_vld | output | 1 | Result valid |
| ccr | output | 5 | Condition codes {X, N, Z, V, C} |
| ccr_we | output | 1 | Condition code write strobe |

## Verification
The assertions assume a single operation per cycle and that op, the selectors and src are stable through the rising edge; they place no restriction on src or mode combinations, so every mode mix is legal. The stimulus drives all inputs on the falling edge, draws op codes over the full 4-bit range including the idle codes, and biases source values towards the sign and range boundaries so that saturation and extension flags are reached. Directed sequences first load known accumulator patterns through extension writes, then read them under each mode.

// File: rtl/acc_xfer_unit.sv
module acc_xfer_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op,
  input  logic [1:0]  dst_sel,
  input  logic [1:0]  src_sel,
  input  logic        rd_clr,
  input  logic [31:0] src,
  output logic [31:0] res,
  output logic        res_vld,
  output logic [4:0]  ccr,
  output logic        ccr_we
);
  localparam logic [3:0] OP_RD_ACC  = 4'd1;
  localparam logic [3:0] OP_WR_ACC  = 4'd2;
  localparam logic [3:0] OP_MOV_ACC = 4'd3;
  localparam logic [3:0] OP_RD_STAT = 4'd4;
  localparam logic [3:0] OP_WR_STAT = 4'd5;
  localparam logic [3:0] OP_RD_MASK = 4'd6;
  localparam logic [3:0] OP_WR_MASK = 4'd7;
  localparam logic [3:0] OP_RD_EXT  = 4'd8;
  localparam logic [3:0] OP_WR_EXT  = 4'd9;
  localparam logic [3:0] OP_STAT_CC = 4'd10;

  logic [47:0] acc_q [4];
  logic [3:0]  flg_q;
  logic [2:0]  mode_q;
  logic [3:0]  ovf_q;
  logic [31:0] mask_q;

  wire sat = mode_q[0];
  wire sgn = mode_q[1];
  wire frc = mode_q[2];

  wire [31:0] stat_rd = {20'd0, ovf_q, 1'b0, mode_q, flg_q};
  wire [1:0]  idx_a   = {dst_sel[1], 1'b0};
  wire [1:0]  idx_b   = {dst_sel[1], 1'b1};

  function automatic logic [3:0] flags_of(input logic [47:0] v, input logic ov);
    logic ev;
    if (frc)      ev = !((&v[47:39]) || !(|v[47:39]));
    else if (sgn) ev = !((&v[47:31]) || !(|v[47:31]));
    else          ev = |v[47:32];
    return {v[47], v == 48'd0, ov, ev};
  endfunction

  function automatic logic [31:0] read_cvt(input logic [47:0] v);
    logic [31:0] r;
    if (frc) begin
      if (sat && !((&v[47:39]) || !(|v[47:39])))
        r = v[47] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else
        r = v[39:8];
    end else if (!sat) begin
      r = v[31:0];
    end else if (sgn) begin
      if ((&v[47:31]) || !(|v[47:31])) r = v[31:0];
      else r = v[47] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    end else begin
      r = (|v[47:32]) ? 32'hFFFF_FFFF : v[31:0];
    end
    return r;
  endfunction

  logic [47:0] wr_val;
  always_comb begin
    if (frc)      wr_val = {{8{src[31]}}, src, 8'h00};
    else if (sgn) wr_val = {{16{src[31]}}, src};
    else          wr_val = {16'h0000, src};
  end

  wire [47:0] mov_val = acc_q[src_sel];
  wire [47:0] acc_a   = acc_q[idx_a];
  wire [47:0] acc_b   = acc_q[idx_b];
  wire [31:0] ext_rd  = frc ? {acc_b[47:40], acc_b[7:0], acc_a[47:40], acc_a[7:0]}
                            : {acc_b[47:32], acc_a[47:32]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) acc_q[i] <= '0;
      flg_q   <= '0;
      mode_q  <= '0;
      ovf_q   <= '0;
      mask_q  <= 32'hFFFF_FFFF;
      res     <= '0;
      res_vld <= 1'b0;
      ccr     <= '0;
      ccr_we  <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      ccr_we  <= 1'b0;
      case (op)
        OP_RD_ACC: begin
          res     <= read_cvt(acc_q[dst_sel]);
          res_vld <= 1'b1;
          if (rd_clr) acc_q[dst_sel] <= '0;
        end
        OP_WR_ACC: begin
          acc_q[dst_sel] <= wr_val;
          flg_q          <= flags_of(wr_val, ovf_q[dst_sel]);
        end
        OP_MOV_ACC: begin
          acc_q[dst_sel] <= mov_val;
          flg_q          <= flags_of(mov_val, ovf_q[dst_sel]);
        end
        OP_RD_STAT: begin
          res     <= stat_rd;
          res_vld <= 1'b1;
        end
        OP_WR_STAT: begin
          flg_q  <= src[3:0];
          mode_q <= src[6:4];
          ovf_q  <= src[11:8];
        end
        OP_RD_MASK: begin
          res     <= mask_q;
          res_vld <= 1'b1;
        end
        OP_WR_MASK: mask_q <= src | 32'hFFFF_0000;
        OP_RD_EXT: begin
          res     <= ext_rd;
          res_vld <= 1'b1;
        end
        OP_WR_EXT: begin
          if (frc) begin
            acc_q[idx_a][47:40] <= src[15:8];
            acc_q[idx_a][7:0]   <= src[7:0];
            acc_q[idx_b][47:40] <= src[31:24];
            acc_q[idx_b][7:0]   <= src[23:16];
          end else begin
            acc_q[idx_a][47:32] <= src[15:0];
            acc_q[idx_b][47:32] <= src[31:16];
          end
        end
        OP_STAT_CC: begin
          ccr    <= {1'b0, flg_q};
          ccr_we <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_VLD_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ($past(op) == OP_RD_ACC || $past(op) == OP_RD_STAT ||
                 $past(op) == OP_RD_MASK || $past(op) == OP_RD_EXT)); // R2

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_ACC && rd_clr) |=> (acc_q[$past(dst_sel)] == 48'd0)); // R4

  AST_WR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR_ACC) |=> ($stable(mode_q) && $stable(ovf_q))); // R5

  AST_MOV_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MOV_ACC) |=> ($stable(mode_q) && $stable(ovf_q))); // R6

  AST_MASK_UPPER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR_MASK) |=> (mask_q[31:16] == 16'hFFFF)); // R8

  AST_CCR_X_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_we |-> (ccr == {1'b0, $past(flg_q)})); // R10
endmodule

// File: tb/sim_acc_xfer_unit.sv
`timescale 1ns/1ps
module sim_acc_xfer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  dst_sel = '0;
  logic [1:0]  src_sel = '0;
  logic        rd_clr = 1'b0;
  logic [31:0] src = '0;
  logic [31:0] res;
  logic        res_vld;
  logic [4:0]  ccr;
  logic        ccr_we;

  int checks = 0;
  int fails  = 0;

  logic [47:0] m_acc [4];
  logic [31:0] m_stat;
  logic [31:0] m_mask;

  acc_xfer_unit u0 (.clk(clk), .rst_n(rst_n), .op(op), .dst_sel(dst_sel),
    .src_sel(src_sel), .rd_clr(rd_clr), .src(src), .res(res), .res_vld(res_vld),
    .ccr(ccr), .ccr_we(ccr_we));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic not_sext(input logic [47:0] v, input int top);
    logic hi_one, hi_zero;
    hi_one = 1'b1; hi_zero = 1'b1;
    for (int i = top; i <= 47; i++) begin
      hi_one  = hi_one & v[i];
      hi_zero = hi_zero & !v[i];
    end
    return !(hi_one || hi_zero);
  endfunction

  function automatic logic [31:0] exp_read(input logic [47:0] v);
    logic f, s, t;
    f = m_stat[6]; s = m_stat[5]; t = m_stat[4];
    if (f) return (t && not_sext(v, 39)) ? (v[47] ? 32'h80000000 : 32'h7FFFFFFF) : v[39:8];
    if (!t) return v[31:0];
    if (s) return not_sext(v, 31) ? (v[47] ? 32'h80000000 : 32'h7FFFFFFF) : v[31:0];
    return (v[47:32] != 0) ? 32'hFFFFFFFF : v[31:0];
  endfunction

  function automatic logic [3:0] exp_flags(input logic [47:0] v, input int idx);
    logic ev;
    if (m_stat[6])      ev = not_sext(v, 39);
    else if (m_stat[5]) ev = not_sext(v, 31);
    else                ev = (v[47:32] != 0);
    return {v[47], (v == 0), m_stat[8+idx], ev};
  endfunction

  task automatic run_op(input logic [3:0] o, input logic [1:0] d, input logic [1:0] s,
                        input logic c, input logic [31:0] val);
    logic [31:0] e_res;
    logic        e_vld;
    logic [47:0] v;
    logic [1:0]  a, b;
    string       tag;
    @(negedge clk);
    op = o; dst_sel = d; src_sel = s; rd_clr = c; src = val;
    e_res = '0; e_vld = 1'b0; tag = "R2";
    a = {d[1], 1'b0}; b = {d[1], 1'b1};
    case (o)
      4'd1: begin e_res = exp_read(m_acc[d]); e_vld = 1'b1; tag = c ? "R4" : "R3";
                  if (c) m_acc[d] = '0; end
      4'd2: begin
        if (m_stat[6])      v = {{8{val[31]}}, val, 8'h00};
        else if (m_stat[5]) v = {{16{val[31]}}, val};
        else                v = {16'h0, val};
        m_acc[d] = v; m_stat[3:0] = exp_flags(v, d);
      end
      4'd3: begin v = m_acc[s]; m_acc[d] = v; m_stat[3:0] = exp_flags(v, d); end
      4'd4: begin e_res = m_stat; e_vld = 1'b1; tag = "R7"; end
      4'd5: m_stat = val & 32'h00000F7F;
      4'd6: begin e_res = m_mask; e_vld = 1'b1; tag = "R8"; end
      4'd7: m_mask = val | 32'hFFFF0000;
      4'd8: begin
        e_vld = 1'b1; tag = "R9";
        e_res = m_stat[6] ? {m_acc[b][47:40], m_acc[b][7:0], m_acc[a][47:40], m_acc[a][7:0]}
                          : {m_acc[b][47:32], m_acc[a][47:32]};
      end
      4'd9: begin
        if (m_stat[6]) begin
          m_acc[a][47:40] = val[15:8];  m_acc[a][7:0] = val[7:0];
          m_acc[b][47:40] = val[31:24]; m_acc[b][7:0] = val[23:16];
        end else begin
          m_acc[a][47:32] = val[15:0];  m_acc[b][47:32] = val[31:16];
        end
      end
      default: ;
    endcase
    @(posedge clk);
    #1;
    op = '0;
    chk("R2 res_vld", {31'd0, res_vld}, {31'd0, e_vld});
    if (e_vld) chk(tag, res, e_res);
    if (o == 4'd10) begin
      chk("R10 ccr", {27'd0, ccr}, {27'd0, 1'b0, m_stat[3:0]});
      chk("R10 ccr_we", {31'd0, ccr_we}, 32'd1);
    end else chk("R10 ccr_we idle", {31'd0, ccr_we}, 32'd0);
  endtask

  function automatic logic [31:0] pick_src();
    case ($urandom % 6)
      0: return 32'h00000000;
      1: return 32'h80000000;
      2: return 32'h7FFFFFFF;
      3: return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1 - 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    m_stat = '0; m_mask = 32'hFFFFFFFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 res", res, 32'd0);
    chk("R1 res_vld", {31'd0, res_vld}, 32'd0);
    chk("R1 ccr_we", {31'd0, ccr_we}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    run_op(4'd4, 0, 0, 0, 0);           // R1 status reset
    run_op(4'd6, 0, 0, 0, 0);           // R1 mask reset
    for (int k = 0; k < 4; k++) run_op(4'd1, 2'(k), 0, 0, 0); // R1 accumulators
    run_op(4'd7, 0, 0, 0, 32'h00001234); // R8
    run_op(4'd6, 0, 0, 0, 0);
    run_op(4'd5, 0, 0, 0, 32'hFFFFFFFF); // R7
    run_op(4'd4, 0, 0, 0, 0);
    run_op(4'd5, 0, 0, 0, 32'h00000050); // fractional + saturate R3
    run_op(4'd2, 2'd1, 0, 0, 32'h40000000); // R5
    run_op(4'd1, 2'd1, 0, 0, 0);
    run_op(4'd9, 2'd0, 0, 0, 32'h12345678); // R9 fractional pack
    run_op(4'd8, 2'd0, 0, 0, 0);
    run_op(4'd1, 2'd1, 0, 0, 0);        // saturated fractional read R3
    run_op(4'd5, 0, 0, 0, 32'h00000030); // signed saturate
    run_op(4'd9, 2'd2, 0, 0, 32'h0001FFFF); // R9 integer pack
    run_op(4'd1, 2'd2, 0, 0, 0);        // R3 negative clamp
    run_op(4'd1, 2'd3, 0, 0, 0);        // R3 positive clamp
    run_op(4'd5, 0, 0, 0, 32'h00000010); // unsigned saturate
    run_op(4'd1, 2'd3, 0, 1, 0);        // R3 unsigned clamp, R4 clear
    run_op(4'd1, 2'd3, 0, 0, 0);        // R4 now zero
    run_op(4'd5, 0, 0, 0, 32'h00000400); // raw, ovf on acc2
    run_op(4'd3, 2'd2, 2'd0, 0, 0);     // R6 copy
    run_op(4'd10, 0, 0, 0, 0);          // R10
    run_op(4'd1, 2'd2, 0, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] o;
      o = 4'($urandom);
      run_op(o, 2'($urandom), 2'($urandom), 1'($urandom), pick_src());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule